// File: doc/BRIEF.md
# Page-Mode EEPROM Write Engine

This block models the device side of a byte-wide electrically erasable memory with an asynchronous static-RAM style bus: active-low chip enable, output enable and write enable, an address bus, and a data bus. The bus is split here into an input path, an output path and an output-enable flag that the pad ring turns into a tri-state driver. A fast system clock samples all bus pins. The block decodes read, write, standby and output-disable from the three control lines, with one register stage of sampling.

Accepted write cycles place bytes into a 128-entry page buffer. A retriggerable load timer is restarted by every byte load and is held while a write pulse is active. When the timer runs out, the engine enters a programming interval of fixed length. The whole page is committed to the internal array at the end of that interval, however many bytes were loaded. While programming, the `busy` output is high and further writes are dropped. A read of the most recently written location returns that byte with its top bit inverted, so software can poll for completion.

Top module: `eeprom_page_engine`

## Requirements
- R1: After reset `busy` and `dataOutEn` are low and every array byte reads as 8'hFF.
- R2: `dataOutEn` is high exactly when, at the previous clock edge, `ceN` and `oeN` were low and `weN` was high. During such a read `dataOut` shows the stored byte at `addr` two falling clock edges after the bus is set up.
- R3: A write is accepted only while `oeN` is high and both `ceN` and `weN` are low. A pulse with `oeN` low has no effect, and so does a write during which `oeN` falls before `ceN` or `weN` rises.
- R4: The address is taken when the write condition first becomes true, which is at the later of the `ceN`/`weN` falling edges. The data is taken from the last cycle before the condition ends, which is at the earlier of their rising edges. Address changes after the start have no effect.
- R5: The page buffer holds 128 bytes indexed by `addr[6:0]`. The page number (`addr[8:7]`) is fixed by the first byte loaded after idle, and later loads in the same page cycle land in that page whatever their upper address bits.
- R6: Every byte load restarts the load timer. Programming begins, and `busy` rises, LOAD_TIMEOUT clock cycles after the last load if no further write intervenes. With the bench's stimulus, `busy` is first high at the (LOAD_TIMEOUT+2)-th sampling point after the final write-enable rise.
- R7: `busy` stays high for exactly PROG_CYCLES cycles, for a one-byte page and for a multi-byte page alike. The loaded bytes appear in the array when `busy` falls.
- R8: While `busy` is high, a read of the last written address returns that byte with bit 7 inverted, and reads of other addresses return the old array contents. Once `busy` is low, the true byte is returned.
- R9: Write cycles that occur while `busy` is high are ignored.
- R10: While a page is loading but not yet programmed, reads return the array's previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| addr | input | 9 | Byte address |
| dataIn | input | 8 | Data bus, inbound |
| dataOut | output | 8 | Data bus, outbound |
| dataOutEn | output | 1 | High when the block drives the data bus |
| busy | output | 1 | High during the programming interval |

## Verification
On every cycle, the assertions check several properties. The bus is driven only after a read condition on the pins. Programming is entered only from the loading state and never while a write pulse is still open. The page-valid mask is non-empty when programming begins, stays frozen during programming and is cleared by the commit. `busy` drops on the cycle after the commit. Only the bench's scenarios can show what ends up in the array. These scenarios cover the data and address capture edges, the retrigger timing measured from the last write, the inverted polling bit, page pinning by the first load, and the fact that inhibited, aborted and mid-programming writes leave no trace.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } engState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic capAddr;     // write condition just opened: capture address
    logic holdData;    // write condition open: track data bus
    logic loadByte;    // write condition closed cleanly: store byte in page
    logic firstLoad;   // no byte in page yet: this load fixes the page
    logic progActive;  // programming interval running
    logic commit;      // last programming cycle: move page to array
  } engStrobe_t;

endpackage

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl
  import eeprom_pkg::*;
#(
  parameter int LOAD_TIMEOUT = 20,
  parameter int PROG_CYCLES  = 60
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceN,
  input  logic       oeN,
  input  logic       weN,
  output engStrobe_t strb,
  output logic       readEn,
  output logic       busy
);

  localparam int CNT_MAX = (LOAD_TIMEOUT > PROG_CYCLES) ? LOAD_TIMEOUT : PROG_CYCLES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic ceS, oeS, weS;
  logic wrActS, wrActQ, wrTaken, endStb;
  logic [CNT_W-1:0] cnt;
  engState_t state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceS <= 1'b1;
      oeS <= 1'b1;
      weS <= 1'b1;
      wrActQ <= 1'b0;
    end else begin
      ceS <= ceN;
      oeS <= oeN;
      weS <= weN;
      wrActQ <= wrActS;
    end
  end

  assign wrActS = !ceS && !weS && oeS;
  assign endStb = wrActQ && !wrActS && oeS;
  assign readEn = !ceS && !oeS && weS;
  assign busy   = (state == ST_PROG);

  always_comb begin
    strb            = '0;
    strb.capAddr    = wrActS && !wrActQ && (state != ST_PROG);
    strb.holdData   = wrActS;
    strb.loadByte   = endStb && wrTaken && (state != ST_PROG);
    strb.firstLoad  = (state == ST_IDLE);
    strb.progActive = (state == ST_PROG);
    strb.commit     = (state == ST_PROG) && (cnt == CNT_W'(PROG_CYCLES - 1));
  end

  // a write is only loaded if its start was accepted
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              wrTaken <= 1'b0;
    else if (strb.capAddr)  wrTaken <= 1'b1;
    else if (!wrActS)       wrTaken <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (strb.loadByte) begin
          state <= ST_LOAD;
          cnt   <= '0;
        end
        ST_LOAD: begin
          if (strb.loadByte || wrActS) cnt <= '0;
          else if (cnt == CNT_W'(LOAD_TIMEOUT - 1)) begin
            state <= ST_PROG;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_PROG: begin
          if (strb.commit) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: programming is reached only from the loading state
  a_r6_prog_from_load: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(state == ST_LOAD));

  // R6: an open write pulse never lets the load timer expire
  a_r6_no_expire_mid_write: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOAD && wrActS) |=> !busy);

  // R7: the commit cycle ends the busy interval
  a_r7_commit_drops_busy: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> !busy);

endmodule

// File: rtl/eeprom_datapath.sv
module eeprom_datapath
  import eeprom_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int DATA_W    = 8,
  parameter int PAGE_BITS = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  engStrobe_t        strb,
  output logic [DATA_W-1:0] dataOut
);

  localparam int DEPTH     = 1 << ADDR_W;
  localparam int PAGE_SIZE = 1 << PAGE_BITS;
  localparam int PAGE_ID_W = ADDR_W - PAGE_BITS;
  localparam logic [DATA_W-1:0] POLL_MASK = DATA_W'(1) << (DATA_W - 1);

  logic [ADDR_W-1:0]    addrS, wrAddr, lastAddr;
  logic [DATA_W-1:0]    dataS, dataHold, lastData;
  logic [PAGE_ID_W-1:0] pageId, loadPage;
  logic [PAGE_SIZE-1:0] validMask;
  logic [DATA_W-1:0]    pageBuf [PAGE_SIZE];
  logic [DATA_W-1:0]    mem     [DEPTH];
  logic [PAGE_BITS-1:0] wrIdx;

  assign wrIdx    = wrAddr[PAGE_BITS-1:0];
  assign loadPage = strb.firstLoad ? wrAddr[ADDR_W-1:PAGE_BITS] : pageId;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrS     <= '0;
      dataS     <= '0;
      wrAddr    <= '0;
      dataHold  <= '0;
      pageId    <= '0;
      lastAddr  <= '0;
      lastData  <= '0;
      validMask <= '0;
    end else begin
      addrS <= addr;
      dataS <= dataIn;
      if (strb.capAddr)  wrAddr   <= addrS;
      if (strb.holdData) dataHold <= dataS;
      if (strb.loadByte) begin
        validMask[wrIdx] <= 1'b1;
        pageId   <= loadPage;
        lastAddr <= {loadPage, wrIdx};
        lastData <= dataHold;
      end else if (strb.commit) begin
        validMask <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.loadByte) pageBuf[wrIdx] <= dataHold;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (strb.commit) begin
      for (int i = 0; i < PAGE_SIZE; i++)
        if (validMask[i]) mem[{pageId, PAGE_BITS'(i)}] <= pageBuf[i];
    end
  end

  always_comb begin
    if (strb.progActive && (addrS == lastAddr)) dataOut = lastData ^ POLL_MASK;
    else                                        dataOut = mem[addrS];
  end

  // R5: programming never starts on an empty page
  a_r5_page_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.progActive) |-> (validMask != '0));

  // R7: the commit empties the page buffer
  a_r7_commit_clears: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> (validMask == '0));

  // R9: page contents frozen while programming
  a_r9_frozen_in_prog: assert property (@(posedge clk) disable iff (!rstN)
    (strb.progActive && !strb.commit) |=> ($stable(validMask) && $stable(lastAddr)));

endmodule

// File: rtl/eeprom_page_engine.sv
module eeprom_page_engine
  import eeprom_pkg::*;
#(
  parameter int ADDR_W       = 9,
  parameter int DATA_W       = 8,
  parameter int PAGE_BITS    = 7,
  parameter int LOAD_TIMEOUT = 20,
  parameter int PROG_CYCLES  = 60
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn,
  output logic              busy
);

  engStrobe_t strb;

  eeprom_ctrl #(
    .LOAD_TIMEOUT(LOAD_TIMEOUT),
    .PROG_CYCLES (PROG_CYCLES)
  ) i_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .ceN   (ceN),
    .oeN   (oeN),
    .weN   (weN),
    .strb  (strb),
    .readEn(dataOutEn),
    .busy  (busy)
  );

  eeprom_datapath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .PAGE_BITS(PAGE_BITS)
  ) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .addr   (addr),
    .dataIn (dataIn),
    .strb   (strb),
    .dataOut(dataOut)
  );

  // R2: the bus is driven only after a read condition on the pins
  a_r2_drive_only_on_read: assert property (@(posedge clk) disable iff (!rstN)
    dataOutEn |-> $past(!ceN && !oeN && weN));

endmodule

// File: tb/test_eeprom_page_engine.sv
module test_eeprom_page_engine;

  localparam int T = 20;
  localparam int P = 60;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ceN = 1'b1, oeN = 1'b1, weN = 1'b1;
  logic [8:0] addr = '0;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut;
  logic       dataOutEn, busy;

  int errors = 0;
  int checks = 0;
  int tick = 0;
  int lastRise = 0;

  typedef struct {
    int         kind;   // 0 data read, 1 dataOutEn, 2 busy
    logic [7:0] val;
    string      req;
  } expItem_t;

  expItem_t expQ[$];
  event monEv;

  always #2 clk = ~clk;
  always @(posedge clk) tick <= tick + 1;

  eeprom_page_engine #(.LOAD_TIMEOUT(T), .PROG_CYCLES(P)) i_eeprom_page_engine (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut),
    .dataOutEn(dataOutEn), .busy(busy)
  );

  // monitor: pops expectations and compares against the outputs
  initial begin
    forever begin
      @(monEv);
      while (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        checks++;
        case (it.kind)
          0: if (dataOutEn !== 1'b1 || dataOut !== it.val) begin
               errors++;
               $display("FAIL %s: read en=%b data=%h expected en=1 data=%h",
                        it.req, dataOutEn, dataOut, it.val);
             end
          1: if (dataOutEn !== it.val[0]) begin
               errors++;
               $display("FAIL %s: dataOutEn=%b expected %b", it.req, dataOutEn, it.val[0]);
             end
          default: if (busy !== it.val[0]) begin
               errors++;
               $display("FAIL %s: busy=%b expected %b", it.req, busy, it.val[0]);
             end
        endcase
      end
    end
  end

  task automatic expectIt(input int kind, input logic [7:0] val, input string req);
    expItem_t it;
    it.kind = kind; it.val = val; it.req = req;
    expQ.push_back(it);
    -> monEv;
    #0;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic waitTo(input int k);
    while (tick < lastRise + k) @(negedge clk);
  endtask

  task automatic writeByte(input logic [8:0] a, input logic [7:0] d);
    addr = a; dataIn = d; oeN = 1'b1; ceN = 1'b0; weN = 1'b0;
    cycles(2);
    weN = 1'b1; ceN = 1'b1;
    lastRise = tick;
    cycles(1);
  endtask

  task automatic readCheck(input logic [8:0] a, input logic [7:0] e, input string req);
    addr = a; ceN = 1'b0; oeN = 1'b0; weN = 1'b1;
    cycles(2);
    expectIt(0, e, req);
    ceN = 1'b1; oeN = 1'b1;
    cycles(1);
  endtask

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cycles(3);
    expectIt(2, 8'h00, "R1");
    expectIt(1, 8'h00, "R1");
    rstN = 1'b1;
    cycles(2);
    expectIt(2, 8'h00, "R1");
    readCheck(9'h005, 8'hFF, "R1");
    readCheck(9'h1FF, 8'hFF, "R1");

    // R2: output disable and standby
    ceN = 1'b0; oeN = 1'b1; weN = 1'b1; cycles(2);
    expectIt(1, 8'h00, "R2 oe high");
    ceN = 1'b1; oeN = 1'b0; cycles(2);
    expectIt(1, 8'h00, "R2 ce high");
    oeN = 1'b1; cycles(1);

    // single byte: timer, busy length, polling
    writeByte(9'h010, 8'hA5);
    waitTo(T + 1);
    expectIt(2, 8'h00, "R6 not yet");
    waitTo(T + 2);
    expectIt(2, 8'h01, "R6 rise");
    readCheck(9'h010, 8'h25, "R8 poll");
    readCheck(9'h011, 8'hFF, "R8 other");
    waitTo(T + P + 1);
    expectIt(2, 8'h01, "R7 one byte still busy");
    waitTo(T + P + 2);
    expectIt(2, 8'h00, "R7 one byte done");
    readCheck(9'h010, 8'hA5, "R8 true data");

    // multi-byte page with retrigger and page pinning
    writeByte(9'h085, 8'h11);
    cycles(10);
    writeByte(9'h086, 8'h22);
    readCheck(9'h085, 8'hFF, "R10 old contents");
    cycles(7);
    writeByte(9'h087, 8'h33);
    cycles(12);
    expectIt(2, 8'h00, "R6 retrigger");
    writeByte(9'h1C9, 8'h44);
    waitTo(T + 1);
    expectIt(2, 8'h00, "R6 page not yet");
    waitTo(T + 2);
    expectIt(2, 8'h01, "R6 page rise");
    begin
      int riseRef;
      riseRef = lastRise;
      writeByte(9'h085, 8'h00);
      lastRise = riseRef;
    end
    readCheck(9'h0C9, 8'hC4, "R8 poll page");
    waitTo(T + P + 1);
    expectIt(2, 8'h01, "R7 page still busy");
    waitTo(T + P + 2);
    expectIt(2, 8'h00, "R7 page done");
    cycles(T + 5);
    expectIt(2, 8'h00, "R9 ignored write did not start a cycle");
    readCheck(9'h085, 8'h11, "R9 byte kept");
    readCheck(9'h086, 8'h22, "R7 page byte");
    readCheck(9'h087, 8'h33, "R7 page byte");
    readCheck(9'h0C9, 8'h44, "R5 pinned page");
    readCheck(9'h1C9, 8'hFF, "R5 upper page untouched");

    // R3: inhibited write (OE low)
    addr = 9'h020; dataIn = 8'h77; oeN = 1'b0; ceN = 1'b0; weN = 1'b0;
    cycles(3);
    ceN = 1'b1; weN = 1'b1; oeN = 1'b1;
    cycles(T + 5);
    expectIt(2, 8'h00, "R3 oe low no cycle");
    // R3: aborted write (OE falls mid-pulse)
    addr = 9'h021; dataIn = 8'h66; ceN = 1'b0; weN = 1'b0;
    cycles(2);
    oeN = 1'b0; cycles(1);
    ceN = 1'b1; weN = 1'b1; oeN = 1'b1;
    cycles(T + 5);
    expectIt(2, 8'h00, "R3 aborted no cycle");
    readCheck(9'h020, 8'hFF, "R3 inhibited");
    readCheck(9'h021, 8'hFF, "R3 aborted");

    // R4: WE-controlled, address moved and data changed during the pulse
    addr = 9'h030; dataIn = 8'h5A; oeN = 1'b1; ceN = 1'b0; weN = 1'b0;
    cycles(2);
    addr = 9'h031; dataIn = 8'h3C;
    cycles(2);
    weN = 1'b1; cycles(1); ceN = 1'b1;
    cycles(2);
    // R4: CE-controlled start, CE rises first
    addr = 9'h040; weN = 1'b0; dataIn = 8'hE1;
    cycles(2);
    addr = 9'h041; ceN = 1'b0;
    cycles(2);
    addr = 9'h042; dataIn = 8'hE2;
    cycles(2);
    ceN = 1'b1;
    lastRise = tick;
    cycles(1);
    weN = 1'b1;
    waitTo(T + P + 4);
    expectIt(2, 8'h00, "R4 programmed");
    readCheck(9'h030, 8'h3C, "R4 we addr at start data at end");
    readCheck(9'h031, 8'hFF, "R4 moved addr unused");
    readCheck(9'h041, 8'hE2, "R4 ce start address");
    readCheck(9'h040, 8'hFF, "R4 address before start unused");
    readCheck(9'h042, 8'hFF, "R4 address after start unused");

    cycles(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule